// File: doc/BRIEF.md
# Synchronized DMA Request Routing Channel

This block is a single routing lane between a bank of peripheral DMA request lines and one DMA controller channel. An 8-bit selector picks one line from the request bus and forwards it toward the controller. In free-running mode the chosen line passes straight through. In gated mode it is held back until a qualified edge shows up on one chosen synchronization input. After that edge, a programmed number of served requests is let through, and then the lane closes again.

A served request is recognised when the forwarded request drops, because the peripheral withdraws it once it has been serviced. A down-counter tracks the served requests. Each time the counter wraps back to its programmed reload value, the lane can emit a one-cycle event pulse. An edge that arrives while the lane is still open sets a sticky overrun flag, and this flag can raise an interrupt. Synchronization inputs are asynchronous. They pass through a two-stage synchronizer and a stability filter before they are used. For a short time after every configuration write, edges are suppressed.

Top module: `dreq_route_chan`

## Requirements
- R1: A selector value of 0, or a value above the number of request lines, routes nothing, and `req_out_o` stays low. A value k in the range 1..N routes `req_in_i[k-1]`.
- R2: With gating disabled, `req_out_o` follows the selected request line in the same cycle.
- R3: With gating enabled, a pending request is forwarded only after an accepted edge on the selected sync input. The polarity code is 2'b01 for rising, 2'b10 for falling, 2'b11 for either edge and 2'b00 for none. A configuration write closes the lane.
- R4: An accepted edge that arrives while the selected request is low is discarded, and any later request stays blocked until another accepted edge arrives.
- R5: After an accepted edge, exactly `reload`+1 served requests pass through. On the last one the counter reloads and the lane closes.
- R6: When events are enabled, `evt_o` is high for exactly one cycle on each counter reload. With `reload` = 0 this means one pulse per served request, and this holds in both modes.
- R7: A sync edge is accepted only when the synchronized level has held its new value for at least three consecutive clock samples. Shorter pulses are ignored.
- R8: Edges are suppressed during the write cycle and for three cycles after any configuration write.
- R9: An accepted edge while the lane is open sets `ovr_flag_o`. The flag stays set until `ovr_clr_i` is pulsed, and `irq_o` equals the flag ANDed with the stored interrupt enable.
- R10: A write changes the 5-bit reload value only if the stored sync-enable and event-enable were both low before that write. Otherwise the old reload value is kept, while the other fields are still updated.
- R11: After reset, `req_out_o`, `evt_o`, `ovr_flag_o` and `irq_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in_i | input | N_REQ_LINES | Peripheral request lines |
| sync_in_i | input | N_SYNC_LINES | Asynchronous synchronization inputs |
| cfg_wr_i | input | 1 | One-cycle configuration write strobe |
| cfg_req_sel_i | input | 8 | Request line selector (0 = none) |
| cfg_sync_sel_i | input | 5 | Sync input index |
| cfg_nbreq_i | input | 5 | Reload value (requests per edge minus one) |
| cfg_pol_i | input | 2 | Edge polarity code |
| cfg_sync_en_i | input | 1 | Gated mode enable |
| cfg_evt_en_i | input | 1 | Event pulse enable |
| cfg_ovr_ie_i | input | 1 | Overrun interrupt enable |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| req_out_o | output | 1 | Request toward the DMA channel |
| evt_o | output | 1 | One-cycle reload event |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Overrun interrupt |

## Verification
The embedded assertions check the following on every cycle:
- a null selector keeps the output low;
- the counter never exceeds the stored reload value;
- event pulses are isolated and occur only while events are enabled;
- the overrun flag is sticky and has a legal cause;
- the lane opens only on an edge with a pending request;
- accepted edges come only from a level held for three samples and never inside the post-write window;
- a locked reload value does not change on a write.

Only the bench scenarios can show how many requests actually pass per edge, how many events a served sequence yields, how each polarity code behaves, and that glitches and masked edges really leave the output closed.

// File: rtl/dreq_route_pkg.sv
package dreq_route_pkg;

    localparam int SEL_W      = 8;
    localparam int SYNC_SEL_W = 5;
    localparam int NB_W       = 5;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } edge_pol_e;

    typedef struct packed {
        logic [SEL_W-1:0]      req_sel;
        logic [SYNC_SEL_W-1:0] sync_sel;
        logic [NB_W-1:0]       nbreq;
        edge_pol_e             pol;
        logic                  sync_en;
        logic                  evt_en;
        logic                  ovr_ie;
    } chan_cfg_t;

    // True when a transition to new_lvl is one the polarity code accepts.
    function automatic logic edge_match(edge_pol_e pol, logic new_lvl);
        return new_lvl ? pol[0] : pol[1];
    endfunction

endpackage

// File: rtl/dreq_cfg_store.sv
module dreq_cfg_store
    import dreq_route_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_i,
    input  logic [SEL_W-1:0]      req_sel_i,
    input  logic [SYNC_SEL_W-1:0] sync_sel_i,
    input  logic [NB_W-1:0]       nbreq_i,
    input  logic [1:0]            pol_i,
    input  logic                  sync_en_i,
    input  logic                  evt_en_i,
    input  logic                  ovr_ie_i,
    output chan_cfg_t             cfg_o,
    output logic [NB_W-1:0]       nb_load_o
);

    chan_cfg_t cfg_q;
    logic      nb_unlocked;

    assign nb_unlocked = !cfg_q.sync_en && !cfg_q.evt_en;
    assign nb_load_o   = (wr_i && nb_unlocked) ? nbreq_i : cfg_q.nbreq;
    assign cfg_o       = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_i) begin
            cfg_q.req_sel  <= req_sel_i;
            cfg_q.sync_sel <= sync_sel_i;
            cfg_q.pol      <= edge_pol_e'(pol_i);
            cfg_q.sync_en  <= sync_en_i;
            cfg_q.evt_en   <= evt_en_i;
            cfg_q.ovr_ie   <= ovr_ie_i;
            if (nb_unlocked) cfg_q.nbreq <= nbreq_i;
        end
    end

    // R10: reload value is frozen while either enable is stored high
    a_r10_nbreq_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (cfg_q.sync_en || cfg_q.evt_en)) |=> $stable(cfg_q.nbreq));

endmodule

// File: rtl/dreq_pick.sv
module dreq_pick #(
    parameter int N    = 8,
    parameter int SW   = 8,
    parameter int BASE = 1
) (
    input  logic [N-1:0]  lines_i,
    input  logic [SW-1:0] sel_i,
    output logic          picked_o
);

    always_comb begin
        picked_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sel_i == SW'(i + BASE)) picked_o = lines_i[i];
        end
    end

endmodule

// File: rtl/dreq_sync_edge.sv
module dreq_sync_edge
    import dreq_route_pkg::*;
#(
    parameter int N_SYNC      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CYC  = 3,
    parameter int MASK_CYC    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_SYNC-1:0]     sync_in_i,
    input  logic [SYNC_SEL_W-1:0] sel_i,
    input  edge_pol_e             pol_i,
    input  logic                  cfg_wr_i,
    output logic                  edge_o
);

    localparam int CW = $clog2(STABLE_CYC + 1);
    localparam int MW = $clog2(MASK_CYC + 1);

    logic [SYNC_STAGES-1:0][N_SYNC-1:0] stg_q;
    logic                               raw;
    logic                               lvl_q;
    logic [CW-1:0]                      run_q;
    logic [MW-1:0]                      mask_q;
    logic                               masked;
    logic                               differ;
    logic                               accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= sync_in_i;
            for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    dreq_pick #(.N(N_SYNC), .SW(SYNC_SEL_W), .BASE(0)) u_sync_pick (
        .lines_i  (stg_q[SYNC_STAGES-1]),
        .sel_i    (sel_i),
        .picked_o (raw)
    );

    assign masked = cfg_wr_i || (mask_q != '0);
    assign differ = (raw != lvl_q);
    assign accept = differ && (run_q == CW'(STABLE_CYC - 1)) && !masked;
    assign edge_o = accept && edge_match(pol_i, raw);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            run_q  <= '0;
            mask_q <= '0;
        end else begin
            if (cfg_wr_i)            mask_q <= MW'(MASK_CYC);
            else if (mask_q != '0)   mask_q <= mask_q - MW'(1);

            if (masked || accept) begin
                lvl_q <= raw;
                run_q <= '0;
            end else if (!differ) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + CW'(1);
            end
        end
    end

    // R7: an accepted edge comes from a level held for three samples
    a_r7_stable_level: assert property (@(posedge clk) disable iff (rst)
        edge_o |-> (raw == $past(raw) && raw == $past(raw, 2)));

    // R8: no edge during or right after a configuration write
    a_r8_write_mask: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_wr_i) || $past(cfg_wr_i, 2) || $past(cfg_wr_i, 3)) |-> !edge_o);

endmodule

// File: rtl/dreq_fwd_ctrl.sv
module dreq_fwd_ctrl
    import dreq_route_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr_i,
    input  logic [NB_W-1:0] nb_load_i,
    input  logic [NB_W-1:0] nbreq_i,
    input  logic            sync_en_i,
    input  logic            evt_en_i,
    input  logic            ovr_ie_i,
    input  logic            picked_i,
    input  logic            sync_edge_i,
    input  logic            ovr_clr_i,
    output logic            req_out_o,
    output logic            evt_o,
    output logic            ovr_flag_o,
    output logic            irq_o
);

    logic            conn_q;
    logic            out_q;
    logic [NB_W-1:0] cnt_q;
    logic            evt_q;
    logic            ovr_q;
    logic            gate_open;
    logic            served;
    logic            underrun;

    assign gate_open = !sync_en_i || conn_q;
    assign req_out_o = picked_i && gate_open;
    assign served    = out_q && !picked_i;
    assign underrun  = served && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            conn_q <= 1'b0;
            out_q  <= 1'b0;
            cnt_q  <= '0;
            evt_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            out_q <= req_out_o;
            evt_q <= underrun && evt_en_i;

            if (cfg_wr_i) begin
                conn_q <= 1'b0;
                cnt_q  <= nb_load_i;
            end else begin
                if (served) begin
                    if (cnt_q == '0) begin
                        cnt_q  <= nbreq_i;
                        conn_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - NB_W'(1);
                    end
                end
                if (sync_en_i && sync_edge_i && !conn_q && picked_i) conn_q <= 1'b1;
            end

            if (sync_en_i && sync_edge_i && conn_q) ovr_q <= 1'b1;
            else if (ovr_clr_i)                     ovr_q <= 1'b0;
        end
    end

    assign evt_o      = evt_q;
    assign ovr_flag_o = ovr_q;
    assign irq_o      = ovr_q && ovr_ie_i;

    // R5: the countdown never exceeds the stored reload value
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= nbreq_i);

    // R4: the lane opens only on an edge that finds a pending request
    a_r4_open_needs_pending: assert property (@(posedge clk) disable iff (rst)
        $rose(conn_q) |-> $past(picked_i && sync_edge_i));

    // R6: event pulses last one cycle and need the enable
    a_r6_evt_single: assert property (@(posedge clk) disable iff (rst)
        evt_q |=> !evt_q);
    a_r6_evt_needs_en: assert property (@(posedge clk) disable iff (rst)
        evt_q |-> $past(evt_en_i));

    // R9: overrun is sticky and only set by an edge in gated mode
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !ovr_clr_i) |=> ovr_q);
    a_r9_set_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(sync_en_i && sync_edge_i));

endmodule

// File: rtl/dreq_route_chan.sv
module dreq_route_chan
    import dreq_route_pkg::*;
#(
    parameter int N_REQ_LINES  = 40,
    parameter int N_SYNC_LINES = 24,
    parameter int SYNC_STAGES  = 2,
    parameter int STABLE_CYC   = 3,
    parameter int MASK_CYC     = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REQ_LINES-1:0]  req_in_i,
    input  logic [N_SYNC_LINES-1:0] sync_in_i,
    input  logic                    cfg_wr_i,
    input  logic [7:0]              cfg_req_sel_i,
    input  logic [4:0]              cfg_sync_sel_i,
    input  logic [4:0]              cfg_nbreq_i,
    input  logic [1:0]              cfg_pol_i,
    input  logic                    cfg_sync_en_i,
    input  logic                    cfg_evt_en_i,
    input  logic                    cfg_ovr_ie_i,
    input  logic                    ovr_clr_i,
    output logic                    req_out_o,
    output logic                    evt_o,
    output logic                    ovr_flag_o,
    output logic                    irq_o
);

    chan_cfg_t       cfg;
    logic [NB_W-1:0] nb_load;
    logic            picked;
    logic            sync_edge;

    dreq_cfg_store u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (cfg_wr_i),
        .req_sel_i  (cfg_req_sel_i),
        .sync_sel_i (cfg_sync_sel_i),
        .nbreq_i    (cfg_nbreq_i),
        .pol_i      (cfg_pol_i),
        .sync_en_i  (cfg_sync_en_i),
        .evt_en_i   (cfg_evt_en_i),
        .ovr_ie_i   (cfg_ovr_ie_i),
        .cfg_o      (cfg),
        .nb_load_o  (nb_load)
    );

    dreq_pick #(.N(N_REQ_LINES), .SW(SEL_W), .BASE(1)) u_req_pick (
        .lines_i  (req_in_i),
        .sel_i    (cfg.req_sel),
        .picked_o (picked)
    );

    dreq_sync_edge #(
        .N_SYNC      (N_SYNC_LINES),
        .SYNC_STAGES (SYNC_STAGES),
        .STABLE_CYC  (STABLE_CYC),
        .MASK_CYC    (MASK_CYC)
    ) u_edge (
        .clk       (clk),
        .rst       (rst),
        .sync_in_i (sync_in_i),
        .sel_i     (cfg.sync_sel),
        .pol_i     (cfg.pol),
        .cfg_wr_i  (cfg_wr_i),
        .edge_o    (sync_edge)
    );

    dreq_fwd_ctrl u_fwd (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_i    (cfg_wr_i),
        .nb_load_i   (nb_load),
        .nbreq_i     (cfg.nbreq),
        .sync_en_i   (cfg.sync_en),
        .evt_en_i    (cfg.evt_en),
        .ovr_ie_i    (cfg.ovr_ie),
        .picked_i    (picked),
        .sync_edge_i (sync_edge),
        .ovr_clr_i   (ovr_clr_i),
        .req_out_o   (req_out_o),
        .evt_o       (evt_o),
        .ovr_flag_o  (ovr_flag_o),
        .irq_o       (irq_o)
    );

    // R1: a null selector never forwards a request
    a_r1_null_sel: assert property (@(posedge clk) disable iff (rst)
        (cfg.req_sel == '0) |-> !req_out_o);

endmodule

// File: tb/dreq_route_chan_tb_top.sv
`timescale 1ns/1ps
module dreq_route_chan_tb_top;

    localparam int NR = 40;
    localparam int NS = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] req_in = '0;
    logic [NS-1:0] sync_in = '0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    c_sel = '0;
    logic [4:0]    c_ssel = '0;
    logic [4:0]    c_nb = '0;
    logic [1:0]    c_pol = '0;
    logic          c_se = 1'b0, c_ee = 1'b0, c_ie = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          req_out, evt, ovr_flag, irq;

    int n_cmp = 0;
    int n_bad = 0;
    int rises = 0;
    int evts = 0;
    logic prev_out = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dreq_route_chan #(.N_REQ_LINES(NR), .N_SYNC_LINES(NS)) dut_i (
        .clk(clk), .rst(rst), .req_in_i(req_in), .sync_in_i(sync_in),
        .cfg_wr_i(cfg_wr), .cfg_req_sel_i(c_sel), .cfg_sync_sel_i(c_ssel),
        .cfg_nbreq_i(c_nb), .cfg_pol_i(c_pol), .cfg_sync_en_i(c_se),
        .cfg_evt_en_i(c_ee), .cfg_ovr_ie_i(c_ie), .ovr_clr_i(ovr_clr),
        .req_out_o(req_out), .evt_o(evt), .ovr_flag_o(ovr_flag), .irq_o(irq)
    );

    // Sampling monitor, one sample per cycle away from the active edge
    always @(negedge clk) begin
        #1;
        if (req_out && !prev_out) rises++;
        prev_out = req_out;
        if (evt) evts++;
    end

    function automatic logic exp_pick(logic [NR-1:0] lines, logic [7:0] sel);
        if (sel >= 8'd1 && sel <= 8'(NR)) return lines[sel - 8'd1];
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic look(input string tag, input int act, input int exp);
        #1;
        chk(tag, act, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfgw(input logic [7:0] sel, input logic [4:0] ss, input logic [4:0] nb,
                        input logic [1:0] pol, input logic se, input logic ee, input logic ie);
        @(negedge clk);
        c_sel = sel; c_ssel = ss; c_nb = nb; c_pol = pol;
        c_se = se; c_ee = ee; c_ie = ie; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic serve_loop(input int n);
        for (int k = 0; k < n; k++) begin
            req_in[2] = 1'b1; step(3);
            req_in[2] = 1'b0; step(3);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] sels [8];
        void'($urandom(32'h5EED_0C4A));
        step(5);
        rst = 1'b0;
        step(1);
        // R11: reset state
        look("R11 req_out", req_out, 0);
        chk("R11 evt", evt, 0);
        chk("R11 ovr_flag", ovr_flag, 0);
        chk("R11 irq", irq, 0);

        // R1 / R2: random pass-through against the bench selection model
        sels = '{8'd0, 8'd1, 8'd17, 8'd40, 8'd41, 8'd200, 8'd3, 8'(1 + $urandom_range(NR - 1))};
        for (int c = 0; c < 8; c++) begin
            cfgw(sels[c], 5'd0, 5'd0, 2'b01, 1'b0, 1'b0, 1'b0);
            for (int t = 0; t < 16; t++) begin
                @(negedge clk);
                req_in = NR'({$urandom(), $urandom()});
                #1;
                if (sels[c] == 0 || sels[c] > NR)
                    chk("R1 null selector", req_out, 0);
                else
                    chk("R2 pass-through", req_out, exp_pick(req_in, sels[c]));
            end
        end
        @(negedge clk); req_in = '0;

        // R3 / R5 / R6: gated, reload 2, events on
        cfgw(8'd3, 5'd4, 5'd2, 2'b01, 1'b0, 1'b0, 1'b0);
        cfgw(8'd3, 5'd4, 5'd2, 2'b01, 1'b1, 1'b1, 1'b0);
        step(4);
        req_in[2] = 1'b1; step(10);
        look("R3 blocked before edge", req_out, 0);
        rises = 0; evts = 0;
        sync_in[4] = 1'b1; step(8);
        look("R3 opens after rising edge", req_out, 1);
        serve_loop(5);
        look("R5 forwarded per edge", rises, 3);
        chk("R6 one event per reload", evts, 1);
        req_in[2] = 1'b1; step(2);
        look("R5 closed after reload", req_out, 0);
        req_in[2] = 1'b0;

        // R4: edge with no pending request is dropped
        cfgw(8'd3, 5'd4, 5'd2, 2'b01, 1'b1, 1'b1, 1'b0);
        sync_in[4] = 1'b0; step(8);
        sync_in[4] = 1'b1; step(8);
        req_in[2] = 1'b1; step(8);
        look("R4 discarded edge keeps lane closed", req_out, 0);
        sync_in[4] = 1'b0; step(8);
        sync_in[4] = 1'b1; step(8);
        look("R4 next edge opens lane", req_out, 1);

        // R9: overrun, interrupt enable, clear
        cfgw(8'd3, 5'd4, 5'd2, 2'b01, 1'b1, 1'b0, 1'b1);
        step(4);
        sync_in[4] = 1'b0; step(8);
        sync_in[4] = 1'b1; step(8);
        look("R9 no overrun on first edge", ovr_flag, 0);
        sync_in[4] = 1'b0; step(8);
        sync_in[4] = 1'b1; step(8);
        look("R9 overrun flag", ovr_flag, 1);
        chk("R9 irq with enable", irq, 1);
        cfgw(8'd3, 5'd4, 5'd2, 2'b01, 1'b1, 1'b0, 1'b0);
        look("R9 irq masked", irq, 0);
        chk("R9 flag sticky across write", ovr_flag, 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        look("R9 flag cleared", ovr_flag, 0);
        req_in[2] = 1'b0;

        // R3: polarity codes (sync currently high)
        cfgw(8'd3, 5'd4, 5'd2, 2'b10, 1'b1, 1'b0, 1'b0);
        step(6);
        req_in[2] = 1'b1; step(8);
        look("R3 falling mode idle", req_out, 0);
        sync_in[4] = 1'b0; step(8);
        look("R3 falling edge opens", req_out, 1);
        req_in[2] = 1'b0;
        cfgw(8'd3, 5'd4, 5'd2, 2'b00, 1'b1, 1'b0, 1'b0);
        step(4);
        req_in[2] = 1'b1;
        sync_in[4] = 1'b1; step(8);
        sync_in[4] = 1'b0; step(8);
        look("R3 polarity none never opens", req_out, 0);
        req_in[2] = 1'b0;
        cfgw(8'd3, 5'd4, 5'd2, 2'b11, 1'b1, 1'b0, 1'b0);
        step(4);
        req_in[2] = 1'b1;
        sync_in[4] = 1'b1; step(8);
        look("R3 both-edge mode opens on rise", req_out, 1);
        req_in[2] = 1'b0;

        // R7: stability filter
        cfgw(8'd3, 5'd4, 5'd2, 2'b01, 1'b1, 1'b0, 1'b0);
        sync_in[4] = 1'b0; step(8);
        req_in[2] = 1'b1;
        sync_in[4] = 1'b1; step(2);
        sync_in[4] = 1'b0; step(10);
        look("R7 two-cycle glitch ignored", req_out, 0);
        sync_in[4] = 1'b1; step(3);
        sync_in[4] = 1'b0; step(10);
        look("R7 three-cycle pulse accepted", req_out, 1);

        // R8: edge starting with the write is masked
        @(negedge clk);
        c_sel = 8'd3; c_ssel = 5'd4; c_nb = 5'd2; c_pol = 2'b01;
        c_se = 1'b1; c_ee = 1'b0; c_ie = 1'b0; cfg_wr = 1'b1;
        sync_in[4] = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        step(10);
        look("R8 masked edge after write", req_out, 0);
        sync_in[4] = 1'b0; step(8);
        sync_in[4] = 1'b1; step(8);
        look("R8 edges resume after window", req_out, 1);
        req_in[2] = 1'b0;

        // R10 / R6: reload lock and per-request events with reload 0
        cfgw(8'd3, 5'd4, 5'd0, 2'b01, 1'b0, 1'b0, 1'b0);
        cfgw(8'd3, 5'd4, 5'd0, 2'b01, 1'b0, 1'b1, 1'b0);
        cfgw(8'd3, 5'd4, 5'd2, 2'b01, 1'b0, 1'b1, 1'b0);
        step(2);
        rises = 0; evts = 0;
        serve_loop(3);
        look("R10 locked reload keeps 0 (R6 event per request)", evts, 3);
        cfgw(8'd3, 5'd4, 5'd0, 2'b01, 1'b0, 1'b0, 1'b0);
        cfgw(8'd3, 5'd4, 5'd2, 2'b01, 1'b0, 1'b1, 1'b0);
        step(2);
        rises = 0; evts = 0;
        serve_loop(6);
        look("R10 unlocked reload takes 2", evts, 2);
        chk("R2 free-running forwards all", rises, 6);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule